// File: doc/BRIEF.md
# Keyed Register Write-Protection Gate

This block guards a bank of protected registers on a 32-bit memory-mapped bus. A write to a protected register goes through only when it directly follows an arming write to a dedicated access-code register. The access-code word has two fields:

- The bits above a configurable mask hold a fixed key.
- The bits under the mask hold the low bits of the byte address that software intends to write next.

The gate qualifies one write enable per protected register. It keeps a registered armed flag and a sticky violation flag.

Each arm is good for exactly one bus write. That write succeeds only if its address matches the stored address bits. Any other write spends the arm. A protected write that is not allowed is silently dropped. Writes to the access-code register are never blocked. Read cycles pass the gate unchanged.

Top module: `keyed_wr_gate`

## Requirements
- R1: After reset, `armed_o` and `viol_o` are 0 and `reg_we_o` is all zero.
- R2: The access-code register sits at byte address `CODE_ADDR` (default 0x904). A write there whose data bits [31:MASK_W] equal `KEY[31:MASK_W]` sets `armed_o` at the next clock edge and stores data bits [MASK_W-1:0]. MASK_W defaults to 16 and KEY to 0xACCE0000. Such a write never asserts any `reg_we_o` bit.
- R3: Protected register i sits at byte address `BANK_BASE + 4*i` (default base 0x1000, 8 registers). While `armed_o` is 1, a write to register i whose address bits [MASK_W-1:0] equal the stored bits asserts only `reg_we_o[i]`, in the same cycle as the write.
- R4: Any write to an address other than `CODE_ADDR` clears `armed_o` at the next clock edge.
- R5: A write to a protected register while `armed_o` is 0 asserts no `reg_we_o` bit and sets `viol_o` at the next edge.
- R6: While armed, a write to a protected register whose low address bits differ from the stored bits has these effects:
  - it asserts no `reg_we_o` bit;
  - it sets `viol_o`;
  - it clears `armed_o`.
- R7: A write to `CODE_ADDR` with a wrong key field sets `viol_o` and leaves `armed_o` at 0, even if the gate was armed before.
- R8: `viol_o` stays 1 once set, until reset.
- R9: Cycles with `bus_we_i` low change neither `armed_o` nor `viol_o` and assert no `reg_we_o` bit, whatever the address.
- R10: A correct access-code write while armed replaces the stored address. Only the new target is then accepted.
- R11: A write to an address that is neither `CODE_ADDR` nor a protected register asserts no enable and does not set `viol_o`. It still spends the arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Bus write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Byte address of the bus access |
| bus_wdata_i | input | DATA_W | Write data |
| reg_we_o | output | NREG | Qualified write enable per protected register |
| armed_o | output | 1 | An arm is pending |
| viol_o | output | 1 | Sticky protection-violation flag |

## Verification
Two functions can fall in the same clock edge: spending a pending arm and taking a new one. This happens when a correct access-code write arrives while the gate is already armed. The bench provokes it with back-to-back arming writes that name different targets. It then judges the outcome from the next data writes. The second target must be granted, and the first must be dropped with a violation. The same edge can also both spend an arm and flag a violation, through a mismatched write or a bad key. The bench checks that `armed_o` falls and `viol_o` rises together.

// File: rtl/keyed_wr_gate_pkg.sv
package keyed_wr_gate_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_CODE  = 2'd1,
    WR_BANK  = 2'd2,
    WR_OTHER = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/keyed_wr_gate_decode.sv
module keyed_wr_gate_decode
  import keyed_wr_gate_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          NREG      = 8,
  parameter logic [31:0] CODE_ADDR = 32'h0000_0904,
  parameter logic [31:0] BANK_BASE = 32'h0000_1000
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_kind_e          kind_o,
  output logic [NREG-1:0]   hit_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] RegAddr = ADDR_W'(BANK_BASE + 32'(4 * i));
    assign hit_o[i] = (addr_i == RegAddr);
  end

  always_comb begin
    if (!we_i)                             kind_o = WR_NONE;
    else if (addr_i == ADDR_W'(CODE_ADDR)) kind_o = WR_CODE;
    else if (|hit_o)                       kind_o = WR_BANK;
    else                                   kind_o = WR_OTHER;
  end
endmodule

// File: rtl/keyed_wr_gate_key.sv
module keyed_wr_gate_key #(
  parameter int          DATA_W = 32,
  parameter int          MASK_W = 16,
  parameter logic [31:0] KEY    = 32'hACCE_0000
) (
  input  logic [DATA_W-1:0] wdata_i,
  output logic              key_ok_o,
  output logic [MASK_W-1:0] tgt_o
);
  localparam logic [DATA_W-1:0] KeyFull = DATA_W'(KEY);

  // only the field outside the mask carries the key
  assign key_ok_o = (wdata_i[DATA_W-1:MASK_W] == KeyFull[DATA_W-1:MASK_W]);
  assign tgt_o    = wdata_i[MASK_W-1:0];
endmodule

// File: rtl/keyed_wr_gate_arm.sv
module keyed_wr_gate_arm
  import keyed_wr_gate_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_kind_e          kind_i,
  input  logic              key_ok_i,
  input  logic [MASK_W-1:0] code_tgt_i,
  input  logic [MASK_W-1:0] addr_low_i,
  output logic              grant_o,
  output logic              armed_o,
  output logic              viol_o
);
  logic              armed_q, armed_d;
  logic              viol_q, viol_d;
  logic [MASK_W-1:0] tgt_q, tgt_d;

  assign grant_o = armed_q && (kind_i == WR_BANK) && (addr_low_i == tgt_q);

  always_comb begin
    armed_d = armed_q;
    tgt_d   = tgt_q;
    viol_d  = viol_q;
    unique case (kind_i)
      WR_CODE: begin
        armed_d = key_ok_i;
        tgt_d   = key_ok_i ? code_tgt_i : tgt_q;
        if (!key_ok_i) viol_d = 1'b1;
      end
      WR_BANK: begin
        armed_d = 1'b0;
        if (!grant_o) viol_d = 1'b1;
      end
      WR_OTHER: armed_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      viol_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      viol_q  <= viol_d;
      tgt_q   <= tgt_d;
    end
  end

  assign armed_o = armed_q;
  assign viol_o  = viol_q;
endmodule

// File: rtl/keyed_wr_gate.sv
module keyed_wr_gate
  import keyed_wr_gate_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          MASK_W    = 16,
  parameter int          NREG      = 8,
  parameter logic [31:0] KEY       = 32'hACCE_0000,
  parameter logic [31:0] CODE_ADDR = 32'h0000_0904,
  parameter logic [31:0] BANK_BASE = 32'h0000_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [NREG-1:0]   reg_we_o,
  output logic              armed_o,
  output logic              viol_o
);
  wr_kind_e          kind;
  logic [NREG-1:0]   hit;
  logic              key_ok;
  logic [MASK_W-1:0] code_tgt;
  logic              grant;

  keyed_wr_gate_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .CODE_ADDR(CODE_ADDR), .BANK_BASE(BANK_BASE)
  ) u_decode (
    .we_i(bus_we_i), .addr_i(bus_addr_i), .kind_o(kind), .hit_o(hit)
  );

  keyed_wr_gate_key #(
    .DATA_W(DATA_W), .MASK_W(MASK_W), .KEY(KEY)
  ) u_key (
    .wdata_i(bus_wdata_i), .key_ok_o(key_ok), .tgt_o(code_tgt)
  );

  keyed_wr_gate_arm #(
    .MASK_W(MASK_W)
  ) u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind), .key_ok_i(key_ok),
    .code_tgt_i(code_tgt), .addr_low_i(bus_addr_i[MASK_W-1:0]),
    .grant_o(grant), .armed_o(armed_o), .viol_o(viol_o)
  );

  assign reg_we_o = hit & {NREG{grant}};
endmodule

// File: rtl/keyed_wr_gate_chk.sv
module keyed_wr_gate_chk #(
  parameter int          ADDR_W    = 32,
  parameter int          NREG      = 8,
  parameter logic [31:0] CODE_ADDR = 32'h0000_0904
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NREG-1:0]   reg_we_o,
  input logic              armed_o,
  input logic              viol_o
);
  // R3
  enable_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_we_o));
  // R5
  enable_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o != '0) |-> (bus_we_i && armed_o));
  // R4
  arm_spent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i != ADDR_W'(CODE_ADDR)) |=> !armed_o);
  // R8
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> ($stable(armed_o) && $stable(viol_o)));
  // R2
  code_no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(CODE_ADDR)) |-> (reg_we_o == '0));
endmodule

bind keyed_wr_gate keyed_wr_gate_chk #(
  .ADDR_W(ADDR_W), .NREG(NREG), .CODE_ADDR(CODE_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .reg_we_o(reg_we_o), .armed_o(armed_o), .viol_o(viol_o)
);

// File: tb/keyed_wr_gate_bench.sv
module keyed_wr_gate_bench;
  localparam logic [31:0] CODE_ADDR = 32'h0000_0904;
  localparam logic [31:0] BANK      = 32'h0000_1000;
  localparam logic [31:0] KEY_HI    = 32'hACCE_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  reg_we;
  logic        armed, viol;
  logic [7:0]  we_seen;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  keyed_wr_gate u_keyed_wr_gate (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .reg_we_o(reg_we), .armed_o(armed), .viol_o(viol)
  );

  function automatic logic [31:0] reg_addr(int i);
    return BANK + 32'(4 * i);
  endfunction

  function automatic logic [31:0] code_for(int i);
    return KEY_HI | (reg_addr(i) & 32'h0000_FFFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(logic w, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #1 we_seen = reg_we;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 armed", 32'(armed), 0);
    chk("R1 viol", 32'(viol), 0);
    chk("R1 we", 32'(reg_we), 0);
  endtask

  task automatic t_arm_write();
    do_reset();
    bus(1, CODE_ADDR, code_for(2));
    chk("R2 no enable", 32'(we_seen), 0);
    chk("R2 armed", 32'(armed), 1);
    bus(1, reg_addr(2), 32'h55);
    chk("R3 enable", 32'(we_seen), 32'h04);
    chk("R4 consumed", 32'(armed), 0);
    chk("R3 no viol", 32'(viol), 0);
  endtask

  task automatic t_idle();
    do_reset();
    bus(1, CODE_ADDR, code_for(5));
    for (int k = 0; k < 3; k++) begin
      bus(0, reg_addr(5), 32'hFFFF);
      chk("R9 idle enable", 32'(we_seen), 0);
    end
    chk("R9 armed kept", 32'(armed), 1);
    bus(1, reg_addr(5), 32'h1);
    chk("R9 arm survives reads", 32'(we_seen), 32'h20);
  endtask

  task automatic t_other();
    do_reset();
    bus(1, CODE_ADDR, code_for(1));
    bus(1, 32'h0000_2000, 32'h7);
    chk("R11 enable", 32'(we_seen), 0);
    chk("R11 armed", 32'(armed), 0);
    chk("R11 viol", 32'(viol), 0);
    bus(1, reg_addr(1), 32'h7);
    chk("R4 spent arm", 32'(we_seen), 0);
  endtask

  task automatic t_unarmed();
    do_reset();
    bus(1, reg_addr(3), 32'h9);
    chk("R5 enable", 32'(we_seen), 0);
    chk("R5 viol", 32'(viol), 1);
  endtask

  task automatic t_mismatch();
    do_reset();
    bus(1, CODE_ADDR, code_for(3));
    bus(1, reg_addr(4), 32'h9);
    chk("R6 enable", 32'(we_seen), 0);
    chk("R6 viol", 32'(viol), 1);
    chk("R6 armed", 32'(armed), 0);
    bus(1, reg_addr(3), 32'h9);
    chk("R6 arm gone", 32'(we_seen), 0);
  endtask

  task automatic t_badkey();
    do_reset();
    bus(1, CODE_ADDR, code_for(0));
    bus(1, CODE_ADDR, code_for(0) ^ 32'h0001_0000);
    chk("R7 armed", 32'(armed), 0);
    chk("R7 viol", 32'(viol), 1);
    bus(1, reg_addr(0), 32'h3);
    chk("R7 no enable", 32'(we_seen), 0);
  endtask

  task automatic t_rearm();
    do_reset();
    bus(1, CODE_ADDR, code_for(6));
    bus(1, CODE_ADDR, code_for(7));
    chk("R10 armed", 32'(armed), 1);
    chk("R10 viol", 32'(viol), 0);
    bus(1, reg_addr(7), 32'h1);
    chk("R10 new target", 32'(we_seen), 32'h80);
    bus(1, CODE_ADDR, code_for(7));
    bus(1, CODE_ADDR, code_for(6));
    bus(1, reg_addr(7), 32'h1);
    chk("R10 old target", 32'(we_seen), 0);
    chk("R10 old viol", 32'(viol), 1);
  endtask

  task automatic t_sticky();
    do_reset();
    bus(1, reg_addr(0), 32'h0);
    for (int k = 0; k < 3; k++) begin
      bus(1, CODE_ADDR, code_for(k));
      bus(1, reg_addr(k), 32'h0);
      chk("R8 good write", 32'(we_seen), 32'(1 << k));
      chk("R8 viol kept", 32'(viol), 1);
    end
    do_reset();
    #1 chk("R1 viol cleared", 32'(viol), 0);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_arm_write();
    t_idle();
    t_other();
    t_unarmed();
    t_mismatch();
    t_badkey();
    t_rearm();
    t_sticky();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule